// File: doc/BRIEF.md
# Serial Memory Protect-Register Controller

This block decides, instruction by instruction, whether a small serial nonvolatile memory may carry out what it has just been told to do. A command shifter upstream hands it one decoded instruction at a time, with a target address and the levels of two enable pins sampled while the instruction was loaded: a program-enable pin and a protect-enable pin. One cycle later the block answers with a go or an abort. The block does no array programming itself.

The block keeps a boundary address, a flag that says the boundary is cleared, and a one-time lock. Any location at or above the boundary is closed to programming. Chip-wide operations need a cleared boundary. Changing the boundary requires a strict chain: the write-enabled state, then a protect-enable instruction, then the change as the very next instruction. A boundary read shifts the stored address out serially. A synchronous reset drops the write-enabled and protect-enabled states and keeps the boundary, its cleared flag and the lock.

Top module: `sprot_guard`

## Requirements
- R1: Opcodes on `cmd_op` are READ=0, EWEN=1, EWDS=2, WRITE=3, ERASE=4, ERAL=5, WRAL=6, PRREAD=7, PREN=8, PRCLEAR=9, PRWRITE=10, PRDS=11, and codes 12 to 15 always abort. Each cycle with `cmd_valid` high gives exactly one result: `res_valid` is high in the next cycle only, and there exactly one of `res_go` and `res_abort` is high.
- R2: READ, EWEN, EWDS, WRITE, ERASE, ERAL and WRAL abort while `pin_pre` is high. EWEN sets the write-enabled state and EWDS clears it. WRITE, ERASE, ERAL and WRAL also need the write-enabled state and `pin_pe` high.
- R3: While the boundary is not cleared, WRITE and ERASE abort for every address greater than or equal to the boundary and may go for addresses below it.
- R4: ERAL and WRAL abort unless the boundary is cleared.
- R5: PREN goes only in the write-enabled state with both `pin_pe` and `pin_pre` high.
- R6: PRCLEAR, PRWRITE and PRDS need both pins high and abort unless the instruction immediately before them was a PREN that went. That qualification lasts for exactly one later instruction, whether or not that instruction uses it.
- R7: PRWRITE aborts unless the boundary is cleared. When it goes, it stores `cmd_addr` as the boundary and marks the boundary as not cleared.
- R8: A PRDS that goes sets a permanent lock. After that PRCLEAR, PRWRITE and PRDS all abort and the stored boundary never changes.
- R9: A PRCLEAR that goes marks the boundary cleared, so WRITE and ERASE at any address, and ERAL and WRAL, may go again.
- R10: PRREAD goes only with `pin_pre` high. From the cycle after it, `rd_busy` is high for 9 cycles and `rd_data` gives a 0 and then the boundary's bits from most to least significant, one bit per rising clock edge.
- R11: Address 0 is a valid boundary: after it is stored, WRITE at address 0 and ERAL abort.
- R12: Synchronous reset clears the write-enabled and protect-enabled states and any readout, and leaves the boundary, the cleared flag and the lock unchanged. After reset `res_valid` and `rd_busy` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A decoded instruction is present this cycle |
| cmd_op | input | 4 | Instruction code |
| cmd_addr | input | AW | Target address or new boundary |
| pin_pe | input | 1 | Program-enable pin level sampled during loading |
| pin_pre | input | 1 | Protect-enable pin level sampled during loading |
| res_valid | output | 1 | Result is present |
| res_go | output | 1 | Instruction may run |
| res_abort | output | 1 | Instruction is refused |
| rd_data | output | 1 | Serial boundary readout |
| rd_busy | output | 1 | Readout in progress |

## Verification
The assertions assume that the upstream shifter presents at most one instruction per cycle and that the pin levels and address on `cmd_op`, `cmd_addr`, `pin_pe` and `pin_pre` are meaningful only in a cycle with `cmd_valid` high. They also assume that no new boundary read arrives while a readout is still shifting. The stimulus always leaves an idle cycle between instructions and waits for each 9-bit readout to finish before it issues the next instruction. Reset is applied only between instructions.

// File: rtl/sprot_pkg.sv
package sprot_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_READ    = 4'd0,
        OP_EWEN    = 4'd1,
        OP_EWDS    = 4'd2,
        OP_WRITE   = 4'd3,
        OP_ERASE   = 4'd4,
        OP_ERAL    = 4'd5,
        OP_WRAL    = 4'd6,
        OP_PRREAD  = 4'd7,
        OP_PREN    = 4'd8,
        OP_PRCLEAR = 4'd9,
        OP_PRWRITE = 4'd10,
        OP_PRDS    = 4'd11
    } op_e;

    // Decision plus side effects for one instruction
    typedef struct packed {
        logic go;
        logic set_wen;
        logic clr_wen;
        logic arm;
        logic do_clear;
        logic do_load;
        logic do_lock;
        logic start_rd;
    } verdict_t;

    // Instructions that require the protect-enable pin low
    function automatic logic is_plain(input op_e op);
        return (op == OP_READ) || (op == OP_EWEN) || (op == OP_EWDS) ||
               (op == OP_WRITE) || (op == OP_ERASE) ||
               (op == OP_ERAL) || (op == OP_WRAL);
    endfunction

    function automatic logic is_addr_prog(input op_e op);
        return (op == OP_WRITE) || (op == OP_ERASE);
    endfunction

    function automatic logic is_chipwide(input op_e op);
        return (op == OP_ERAL) || (op == OP_WRAL);
    endfunction

    // Instructions that alter the protect register
    function automatic logic is_prot_change(input op_e op);
        return (op == OP_PRCLEAR) || (op == OP_PRWRITE) || (op == OP_PRDS);
    endfunction

endpackage

// File: rtl/sprot_rules.sv
module sprot_rules
    import sprot_pkg::*;
#(
    parameter int AW = 8
) (
    input  op_e            op,
    input  logic [AW-1:0]  addr,
    input  logic           pe,
    input  logic           pre,
    input  logic           wen,
    input  logic           armed,
    input  logic           cleared,
    input  logic           locked,
    input  logic [AW-1:0]  boundary,
    output verdict_t       v
);

    logic open_addr;
    logic reg_access;

    assign open_addr  = cleared || (addr < boundary);
    assign reg_access = pre && pe && armed && !locked;

    always_comb begin
        v = '0;
        case (op)
            OP_READ: begin
                v.go = !pre;
            end
            OP_EWEN: begin
                v.go      = !pre;
                v.set_wen = 1'b1;
            end
            OP_EWDS: begin
                v.go      = !pre;
                v.clr_wen = 1'b1;
            end
            OP_WRITE, OP_ERASE: begin
                v.go = !pre && pe && wen && open_addr;
            end
            OP_ERAL, OP_WRAL: begin
                v.go = !pre && pe && wen && cleared;
            end
            OP_PRREAD: begin
                v.go       = pre;
                v.start_rd = 1'b1;
            end
            OP_PREN: begin
                v.go  = pre && pe && wen;
                v.arm = 1'b1;
            end
            OP_PRCLEAR: begin
                v.go       = reg_access;
                v.do_clear = 1'b1;
            end
            OP_PRWRITE: begin
                v.go      = reg_access && cleared;
                v.do_load = 1'b1;
            end
            OP_PRDS: begin
                v.go      = reg_access;
                v.do_lock = 1'b1;
            end
            default: begin
                v = '0;
            end
        endcase
    end

endmodule

// File: rtl/sprot_state.sv
module sprot_state
    import sprot_pkg::*;
#(
    parameter int           AW            = 8,
    parameter logic [AW-1:0] INIT_BOUND   = '0,
    parameter logic          INIT_CLEARED = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           fire,
    input  verdict_t       v,
    input  logic [AW-1:0]  load_addr,
    output logic           wen,
    output logic           armed,
    output logic           cleared,
    output logic           locked,
    output logic [AW-1:0]  boundary
);

    // Volatile mode state: cleared by reset
    always_ff @(posedge clk) begin
        if (rst) begin
            wen   <= 1'b0;
            armed <= 1'b0;
        end else if (fire) begin
            armed <= v.go && v.arm;
            if (v.go && v.set_wen) wen <= 1'b1;
            if (v.go && v.clr_wen) wen <= 1'b0;
        end
    end

    // Protect register: kept across reset, power-up values from parameters
    logic           clr_q  = INIT_CLEARED;
    logic           lock_q = 1'b0;
    logic [AW-1:0]  bnd_q  = INIT_BOUND;

    always_ff @(posedge clk) begin
        if (fire && v.go) begin
            if (v.do_clear) clr_q <= 1'b1;
            if (v.do_load) begin
                bnd_q <= load_addr;
                clr_q <= 1'b0;
            end
            if (v.do_lock) lock_q <= 1'b1;
        end
    end

    assign cleared  = clr_q;
    assign locked   = lock_q;
    assign boundary = bnd_q;

    // R8
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> (locked && $stable(boundary) && $stable(cleared)));

    // R6
    arm_once_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && fire && !v.arm) |=> !armed);

    // R7
    load_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && v.go && v.do_load) |=> (!cleared && boundary == $past(load_addr)));

endmodule

// File: rtl/sprot_shift.sv
module sprot_shift #(
    parameter int AW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [AW-1:0]  value,
    output logic           dout,
    output logic           busy
);

    localparam int SW = AW + 1;
    localparam int CW = $clog2(SW + 1);

    logic [SW-1:0] sh;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            sh  <= '0;
        end else if (start) begin
            cnt <= CW'(SW);
            sh  <= {1'b0, value};
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            sh  <= {sh[SW-2:0], 1'b0};
        end
    end

    assign busy = (cnt != '0);
    assign dout = busy && sh[SW-1];

    // R10
    rd_lead_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && !dout));

    // R10
    rd_first_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> ##1 (dout == $past(value[AW-1], 2)));

endmodule

// File: rtl/sprot_guard.sv
module sprot_guard
    import sprot_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cmd_valid,
    input  logic [3:0]     cmd_op,
    input  logic [AW-1:0]  cmd_addr,
    input  logic           pin_pe,
    input  logic           pin_pre,
    output logic           res_valid,
    output logic           res_go,
    output logic           res_abort,
    output logic           rd_data,
    output logic           rd_busy
);

    op_e           op;
    verdict_t      v;
    logic          wen, armed, cleared, locked;
    logic [AW-1:0] boundary;

    assign op = op_e'(cmd_op);

    sprot_rules #(.AW(AW)) u_rules (
        .op       (op),
        .addr     (cmd_addr),
        .pe       (pin_pe),
        .pre      (pin_pre),
        .wen      (wen),
        .armed    (armed),
        .cleared  (cleared),
        .locked   (locked),
        .boundary (boundary),
        .v        (v)
    );

    sprot_state #(.AW(AW)) u_state (
        .clk       (clk),
        .rst       (rst),
        .fire      (cmd_valid),
        .v         (v),
        .load_addr (cmd_addr),
        .wen       (wen),
        .armed     (armed),
        .cleared   (cleared),
        .locked    (locked),
        .boundary  (boundary)
    );

    sprot_shift #(.AW(AW)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (cmd_valid && v.go && v.start_rd),
        .value (boundary),
        .dout  (rd_data),
        .busy  (rd_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_go    <= 1'b0;
        end else begin
            res_valid <= cmd_valid;
            res_go    <= cmd_valid && v.go;
        end
    end

    assign res_abort = res_valid && !res_go;

    // R1
    res_timing_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> (res_valid && (res_go != res_abort)));

    // R1
    res_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> (!res_valid && !res_go && !res_abort));

    // R2
    plain_pre_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && is_plain(op) && pin_pre) |=> !res_go);

    // R3
    prot_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && is_addr_prog(op) && !cleared && cmd_addr >= boundary) |=> !res_go);

    // R4
    chip_wide_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && is_chipwide(op) && !cleared) |=> !res_go);

    // R6
    chain_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && is_prot_change(op) && !armed) |=> !res_go);

    // R5
    pren_wen_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == OP_PREN && !wen) |=> !res_go);

endmodule

// File: tb/sprot_guard_tb.sv
module sprot_guard_tb;

    localparam int AW = 8;

    localparam logic [3:0] C_READ = 4'd0, C_EWEN = 4'd1, C_EWDS = 4'd2,
        C_WRITE = 4'd3, C_ERASE = 4'd4, C_ERAL = 4'd5, C_WRAL = 4'd6,
        C_PRREAD = 4'd7, C_PREN = 4'd8, C_PRCLEAR = 4'd9,
        C_PRWRITE = 4'd10, C_PRDS = 4'd11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [3:0] cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic pin_pe = 1'b0;
    logic pin_pre = 1'b0;
    logic res_valid, res_go, res_abort, rd_data, rd_busy;

    always #2 clk = ~clk;

    sprot_guard #(.AW(AW)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .pin_pe    (pin_pe),
        .pin_pre   (pin_pre),
        .res_valid (res_valid),
        .res_go    (res_go),
        .res_abort (res_abort),
        .rd_data   (rd_data),
        .rd_busy   (rd_busy)
    );

    typedef struct {
        logic  go;
        string tag;
    } exp_t;

    exp_t sb[$];
    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected decision whenever a result appears
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1 unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(res_go == e.go, e.tag, int'(res_go), int'(e.go));
                check(res_abort == !e.go, {e.tag, " abort"}, int'(res_abort), int'(!e.go));
            end
        end
    end

    task automatic issue(input logic [3:0] op, input logic [AW-1:0] a,
                         input logic pe, input logic pre, input logic eg, input string tag);
        exp_t e;
        @(negedge clk);
        cmd_op = op; cmd_addr = a; pin_pe = pe; pin_pre = pre; cmd_valid = 1'b1;
        e.go = eg; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic read_bound(input logic [AW-1:0] exp, input string tag);
        issue(C_PRREAD, '0, 1'b0, 1'b1, 1'b1, tag);
        check(rd_busy == 1'b1, {tag, " busy"}, int'(rd_busy), 1);
        check(rd_data == 1'b0, {tag, " lead zero"}, int'(rd_data), 0);
        for (int i = AW - 1; i >= 0; i--) begin
            @(negedge clk);
            check(rd_data == exp[i], {tag, " data bit"}, int'(rd_data), int'(exp[i]));
        end
        @(negedge clk);
        check(rd_busy == 1'b0, {tag, " done"}, int'(rd_busy), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        check(res_valid == 1'b0, "R12 res_valid after reset", int'(res_valid), 0);
        check(rd_busy == 1'b0, "R12 rd_busy after reset", int'(rd_busy), 0);

        // R2 plain instructions and the protect-enable pin
        issue(C_READ, 8'h00, 1'b0, 1'b0, 1'b1, "R2 read pre low");
        issue(C_READ, 8'h00, 1'b0, 1'b1, 1'b0, "R2 read pre high");
        issue(C_WRITE, 8'h05, 1'b1, 1'b0, 1'b0, "R2 write without ewen");
        issue(C_EWEN, 8'h00, 1'b0, 1'b1, 1'b0, "R2 ewen pre high");
        issue(C_EWEN, 8'h00, 1'b0, 1'b0, 1'b1, "R2 ewen");
        issue(C_WRITE, 8'h05, 1'b1, 1'b0, 1'b1, "R2 write enabled");
        issue(C_WRITE, 8'h05, 1'b0, 1'b0, 1'b0, "R2 write pe low");
        issue(12, 8'h00, 1'b1, 1'b0, 1'b0, "R1 unused code");
        read_bound(8'h00, "R10 initial readout");
        issue(C_PRREAD, 8'h00, 1'b0, 1'b0, 1'b0, "R10 prread pre low");
        @(negedge clk);
        check(rd_busy == 1'b0, "R10 no readout on abort", int'(rd_busy), 0);
        issue(C_ERAL, 8'h00, 1'b1, 1'b0, 1'b1, "R4 eral cleared");

        // R5 R6 R7 chain to set a boundary
        issue(C_PRWRITE, 8'h80, 1'b1, 1'b1, 1'b0, "R6 prwrite unarmed");
        issue(C_PREN, 8'h00, 1'b0, 1'b1, 1'b0, "R5 pren pe low");
        issue(C_PREN, 8'h00, 1'b1, 1'b1, 1'b1, "R5 pren");
        issue(C_PRWRITE, 8'h80, 1'b1, 1'b1, 1'b1, "R7 prwrite");
        read_bound(8'h80, "R7 readout");

        // R3 R4 boundary at 0x80
        issue(C_WRITE, 8'h7F, 1'b1, 1'b0, 1'b1, "R3 write below");
        issue(C_WRITE, 8'h80, 1'b1, 1'b0, 1'b0, "R3 write at boundary");
        issue(C_ERASE, 8'hFF, 1'b1, 1'b0, 1'b0, "R3 erase above");
        issue(C_ERASE, 8'h00, 1'b1, 1'b0, 1'b1, "R3 erase below");
        issue(C_ERAL, 8'h00, 1'b1, 1'b0, 1'b0, "R4 eral protected");
        issue(C_WRAL, 8'h00, 1'b1, 1'b0, 1'b0, "R4 wral protected");

        // R7 write needs cleared
        issue(C_PREN, 8'h00, 1'b1, 1'b1, 1'b1, "R5 pren again");
        issue(C_PRWRITE, 8'h40, 1'b1, 1'b1, 1'b0, "R7 prwrite not cleared");
        read_bound(8'h80, "R7 boundary kept");

        // R6 qualifier lasts one instruction
        issue(C_PREN, 8'h00, 1'b1, 1'b1, 1'b1, "R6 pren");
        issue(C_READ, 8'h00, 1'b0, 1'b0, 1'b1, "R6 intervening read");
        issue(C_PRCLEAR, 8'h00, 1'b1, 1'b1, 1'b0, "R6 prclear stale");
        issue(C_PREN, 8'h00, 1'b1, 1'b1, 1'b1, "R6 pren fresh");
        issue(C_PRCLEAR, 8'h00, 1'b1, 1'b0, 1'b0, "R6 prclear pre low");
        issue(C_PREN, 8'h00, 1'b1, 1'b1, 1'b1, "R6 pren fresh 2");
        issue(C_PRCLEAR, 8'h00, 1'b1, 1'b1, 1'b1, "R9 prclear");

        // R9 everything open again
        issue(C_WRITE, 8'hFF, 1'b1, 1'b0, 1'b1, "R9 write top");
        issue(C_WRAL, 8'h00, 1'b1, 1'b0, 1'b1, "R9 wral");

        // R11 boundary at address 0
        issue(C_PREN, 8'h00, 1'b1, 1'b1, 1'b1, "R11 pren");
        issue(C_PRWRITE, 8'h00, 1'b1, 1'b1, 1'b1, "R11 prwrite zero");
        issue(C_WRITE, 8'h00, 1'b1, 1'b0, 1'b0, "R11 write addr 0");
        issue(C_ERAL, 8'h00, 1'b1, 1'b0, 1'b0, "R11 eral");

        // R12 reset drops modes, keeps protect register
        do_reset();
        issue(C_PREN, 8'h00, 1'b1, 1'b1, 1'b0, "R12 pren after reset");
        issue(C_EWEN, 8'h00, 1'b0, 1'b0, 1'b1, "R12 ewen");
        issue(C_PREN, 8'h00, 1'b1, 1'b1, 1'b1, "R12 pren armed");
        do_reset();
        issue(C_PRCLEAR, 8'h00, 1'b1, 1'b1, 1'b0, "R12 arm dropped");
        read_bound(8'h00, "R12 boundary kept");
        issue(C_EWEN, 8'h00, 1'b0, 1'b0, 1'b1, "R12 ewen 2");
        issue(C_ERAL, 8'h00, 1'b1, 1'b0, 1'b0, "R12 cleared flag kept");

        // R8 permanent lock
        issue(C_PREN, 8'h00, 1'b1, 1'b1, 1'b1, "R8 pren a");
        issue(C_PRCLEAR, 8'h00, 1'b1, 1'b1, 1'b1, "R8 prclear");
        issue(C_PREN, 8'h00, 1'b1, 1'b1, 1'b1, "R8 pren b");
        issue(C_PRWRITE, 8'h20, 1'b1, 1'b1, 1'b1, "R8 prwrite");
        issue(C_PREN, 8'h00, 1'b1, 1'b1, 1'b1, "R8 pren c");
        issue(C_PRDS, 8'h00, 1'b1, 1'b1, 1'b1, "R8 prds");
        issue(C_PREN, 8'h00, 1'b1, 1'b1, 1'b1, "R8 pren d");
        issue(C_PRCLEAR, 8'h00, 1'b1, 1'b1, 1'b0, "R8 prclear locked");
        issue(C_PREN, 8'h00, 1'b1, 1'b1, 1'b1, "R8 pren e");
        issue(C_PRWRITE, 8'h10, 1'b1, 1'b1, 1'b0, "R8 prwrite locked");
        issue(C_PREN, 8'h00, 1'b1, 1'b1, 1'b1, "R8 pren f");
        issue(C_PRDS, 8'h00, 1'b1, 1'b1, 1'b0, "R8 prds locked");
        read_bound(8'h20, "R8 boundary frozen");
        issue(C_WRITE, 8'h1F, 1'b1, 1'b0, 1'b1, "R8 write below");
        issue(C_WRITE, 8'h20, 1'b1, 1'b0, 1'b0, "R8 write at boundary");
        do_reset();
        issue(C_EWEN, 8'h00, 1'b0, 1'b0, 1'b1, "R8 ewen after reset");
        issue(C_PREN, 8'h00, 1'b1, 1'b1, 1'b1, "R8 pren g");
        issue(C_PRCLEAR, 8'h00, 1'b1, 1'b1, 1'b0, "R8 lock survives reset");
        read_bound(8'h20, "R8 boundary after reset");
        issue(C_EWDS, 8'h00, 1'b0, 1'b0, 1'b1, "R2 ewds");
        issue(C_WRITE, 8'h00, 1'b1, 1'b0, 1'b0, "R2 write after ewds");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R1 all results seen", sb.size(), 0);
        finish_run();
    end

endmodule